// File: doc/BRIEF.md
# Gated 40-bit Multiply-Accumulate Coprocessor

This block is a small coprocessor datapath beside a host core. It keeps one private 40-bit accumulator that every multiply-accumulate command updates. No command names a destination register. The host presents commands on a valid/ready port. Each command carries an opcode, two 32-bit source operands and two halfword select bits. Every command completes in the cycle it is accepted. The port never stalls.

Three arithmetic commands are supported. The first multiplies two full signed words. The second multiplies both halfword pairs and adds the two products. The third multiplies one chosen halfword of each operand. Two further commands load the accumulator from the operands and return its value on a two-word read port.

Use of the block is gated by a single access-enable bit, which only a privileged configuration write can change. When the enable bit is clear, a command does not run. Instead, the block pulses an undefined-instruction exception output, which the host turns into a trap. The host's context-switch code is responsible for saving and restoring the accumulator.

Top module: `mac40_cop`

## Requirements
- R1: After reset the accumulator is zero, the access-enable bit is zero, and `undef_exc` and `rd_valid` are low. The first read after enabling returns zero.
- R2: Opcode 1 multiplies `cmd_a` by `cmd_b` as signed 32-bit values, adds the product to the accumulator and wraps modulo 2^40, with no saturation.
- R3: Opcode 2 forms the signed 16x16 product of the upper halves and the signed 16x16 product of the lower halves. It sign-extends both products and adds both to the accumulator, modulo 2^40.
- R4: Opcode 3 adds the signed product of one halfword of each operand, modulo 2^40. `cmd_sel[1]`=1 picks `cmd_a[31:16]` (otherwise `cmd_a[15:0]`), and `cmd_sel[0]`=1 picks `cmd_b[31:16]` (otherwise `cmd_b[15:0]`).
- R5: Opcode 4 loads accumulator bits [31:0] from `cmd_a` and bits [39:32] from `cmd_b[7:0]`.
- R6: Opcode 5 raises `rd_valid` for one cycle, on the cycle after acceptance. `rd_lo` then holds accumulator bits [31:0] and `rd_hi` holds bits [39:32] sign-extended to 32 bits. The value returned includes every command accepted before the read.
- R7: A write with `cfg_we`=1 and `cfg_priv`=1 sets the enable bit to `cfg_enable`. The new value applies to commands accepted after that edge. While the bit is 0, any accepted command leaves the accumulator unchanged, raises `undef_exc` for exactly the next cycle and gives no `rd_valid`.
- R8: A configuration write with `cfg_priv`=0 leaves the enable bit unchanged.
- R9: Opcodes 0, 6 and 7 are refused even while enabled. The accumulator is left unchanged and `undef_exc` is raised for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 3 | Opcode |
| cmd_a | input | 32 | First source operand |
| cmd_b | input | 32 | Second source operand |
| cmd_sel | input | 2 | Halfword selects for opcode 3 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Write comes from privileged software |
| cfg_enable | input | 1 | New access-enable value |
| rd_valid | output | 1 | Read data valid |
| rd_lo | output | 32 | Accumulator bits [31:0] |
| rd_hi | output | 32 | Accumulator bits [39:32], sign-extended |
| undef_exc | output | 1 | Undefined-instruction exception pulse |

## Verification
A corrupted accumulator produces no output until the host reads it. The fault therefore shows on `rd_lo`/`rd_hi` in the cycle after the next opcode-5 command, and then keeps propagating through every later sum. For that reason, the random stream mixes reads in often, and directed reads follow each corner case.

A wrong enable bit or a wrong opcode decode appears on `undef_exc` one cycle after the offending command. The bench therefore compares `undef_exc` and `rd_valid` after every single command.

// File: rtl/mac40_pkg.sv
package mac40_pkg;

   typedef enum logic [2:0] {
      OP_NONE    = 3'd0,
      OP_MULWORD = 3'd1,
      OP_MULPAIR = 3'd2,
      OP_MULSEL  = 3'd3,
      OP_LOAD    = 3'd4,
      OP_FETCH   = 3'd5
   } mac_op_e;

   function automatic logic op_is_legal(input logic [2:0] op);
      return (op >= 3'd1) && (op <= 3'd5);
   endfunction

   function automatic logic op_is_arith(input logic [2:0] op);
      return (op >= 3'd1) && (op <= 3'd3);
   endfunction

endpackage

// File: rtl/mac40_gate.sv
module mac40_gate
   import mac40_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_priv,
   input  logic       cfg_enable,
   input  logic       fire,
   input  logic [2:0] op,
   output logic       en_q,
   output logic       run,
   output logic       undef_q
);

   logic refuse;

   assign run    = fire && en_q && op_is_legal(op);
   assign refuse = fire && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         undef_q <= 1'b0;
      end else begin
         if (cfg_we && cfg_priv)
            en_q <= cfg_enable;
         undef_q <= refuse;
      end
   end

endmodule

// File: rtl/mac40_prod.sv
module mac40_prod
   import mac40_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        sel,
   output logic [ACC_W-1:0]  addend
);

   localparam int HALF_W = DATA_W / 2;
   localparam int WEXT_W = ACC_W - DATA_W;
   localparam int HEXT_W = ACC_W - HALF_W;

   logic [ACC_W-1:0] lane_p [2];
   logic [ACC_W-1:0] word_p, pick_p;
   logic [ACC_W-1:0] sa, sb;

   // Full-word product, computed modulo 2^ACC_W on sign-extended operands
   assign word_p = {{WEXT_W{a[DATA_W-1]}}, a} * {{WEXT_W{b[DATA_W-1]}}, b};

   // Lane 0 = lower halves, lane 1 = upper halves
   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         logic [HALF_W-1:0] ha, hb;
         assign ha = a[g*HALF_W +: HALF_W];
         assign hb = b[g*HALF_W +: HALF_W];
         assign lane_p[g] = {{HEXT_W{ha[HALF_W-1]}}, ha} * {{HEXT_W{hb[HALF_W-1]}}, hb};
      end
   endgenerate

   always_comb begin
      sa = sel[1] ? {{HEXT_W{a[DATA_W-1]}}, a[DATA_W-1:HALF_W]}
                  : {{HEXT_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
      sb = sel[0] ? {{HEXT_W{b[DATA_W-1]}}, b[DATA_W-1:HALF_W]}
                  : {{HEXT_W{b[HALF_W-1]}}, b[HALF_W-1:0]};
   end

   assign pick_p = sa * sb;

   always_comb begin
      case (mac_op_e'(op))
         OP_MULWORD: addend = word_p;
         OP_MULPAIR: addend = lane_p[0] + lane_p[1];
         OP_MULSEL:  addend = pick_p;
         default:    addend = '0;
      endcase
   end

endmodule

// File: rtl/mac40_acc.sv
module mac40_acc
   import mac40_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic [2:0]                op,
   input  logic [DATA_W-1:0]         a,
   input  logic [ACC_W-DATA_W-1:0]   b_lo,
   input  logic [ACC_W-1:0]          addend,
   output logic [ACC_W-1:0]          acc_q,
   output logic                      rd_valid,
   output logic [DATA_W-1:0]         rd_lo,
   output logic [DATA_W-1:0]         rd_hi
);

   localparam int TOP_W = ACC_W - DATA_W;
   localparam int PAD_W = DATA_W - TOP_W;

   logic [ACC_W-1:0]  acc_d;
   logic [DATA_W-1:0] hi_ext;

   always_comb begin
      acc_d = acc_q;
      if (run) begin
         if (op_is_arith(op))
            acc_d = acc_q + addend;
         else if (mac_op_e'(op) == OP_LOAD)
            acc_d = {b_lo, a};
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign hi_ext = {{PAD_W{acc_q[ACC_W-1]}}, acc_q[ACC_W-1:DATA_W]};
      end else begin : g_nopad
         assign hi_ext = acc_q[ACC_W-1:DATA_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         rd_valid <= 1'b0;
         rd_lo    <= '0;
         rd_hi    <= '0;
      end else begin
         acc_q    <= acc_d;
         rd_valid <= run && (mac_op_e'(op) == OP_FETCH);
         if (run && (mac_op_e'(op) == OP_FETCH)) begin
            rd_lo <= acc_q[DATA_W-1:0];
            rd_hi <= hi_ext;
         end
      end
   end

endmodule

// File: rtl/mac40_cop.sv
module mac40_cop
   import mac40_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_a,
   input  logic [DATA_W-1:0] cmd_b,
   input  logic [1:0]        cmd_sel,
   input  logic              cfg_we,
   input  logic              cfg_priv,
   input  logic              cfg_enable,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_lo,
   output logic [DATA_W-1:0] rd_hi,
   output logic              undef_exc
);

   localparam int TOP_W = ACC_W - DATA_W;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_even
         $error("DATA_W must be even");
      end
      if (TOP_W < 1 || TOP_W > DATA_W) begin : g_bad_acc
         $error("ACC_W must lie between DATA_W+1 and 2*DATA_W");
      end
   endgenerate

   logic             fire, run, en_q;
   logic [ACC_W-1:0] addend, acc_q;

   assign cmd_ready = 1'b1;
   assign fire      = cmd_valid && cmd_ready;

   mac40_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_priv   (cfg_priv),
      .cfg_enable (cfg_enable),
      .fire       (fire),
      .op         (cmd_op),
      .en_q       (en_q),
      .run        (run),
      .undef_q    (undef_exc)
   );

   mac40_prod #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_prod (
      .op     (cmd_op),
      .a      (cmd_a),
      .b      (cmd_b),
      .sel    (cmd_sel),
      .addend (addend)
   );

   mac40_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .op       (cmd_op),
      .a        (cmd_a),
      .b_lo     (cmd_b[TOP_W-1:0]),
      .addend   (addend),
      .acc_q    (acc_q),
      .rd_valid (rd_valid),
      .rd_lo    (rd_lo),
      .rd_hi    (rd_hi)
   );

endmodule

// File: rtl/mac40_cop_chk.sv
module mac40_cop_chk #(
   parameter int DATA_W = 32,
   parameter int ACC_W  = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic [DATA_W-1:0] cmd_a,
   input logic [DATA_W-1:0] cmd_b,
   input logic              cfg_we,
   input logic              cfg_priv,
   input logic              en_q,
   input logic [ACC_W-1:0]  acc_q,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_lo,
   input logic              undef_exc
);

   logic bad_op;
   assign bad_op = (cmd_op == 3'd0) || (cmd_op > 3'd5);

   p_refuse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !en_q |=> acc_q == $past(acc_q));

   p_refuse_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !en_q |=> undef_exc && !rd_valid);

   p_unpriv_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_priv |=> en_q == $past(en_q));

   p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && en_q && bad_op |=> undef_exc && acc_q == $past(acc_q));

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && en_q && cmd_op == 3'd4
      |=> acc_q == {$past(cmd_b[ACC_W-DATA_W-1:0]), $past(cmd_a)});

   p_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && en_q && cmd_op == 3'd5
      |=> rd_valid && rd_lo == $past(acc_q[DATA_W-1:0]));

   p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && undef_exc));

endmodule

bind mac40_cop mac40_cop_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_a     (cmd_a),
   .cmd_b     (cmd_b),
   .cfg_we    (cfg_we),
   .cfg_priv  (cfg_priv),
   .en_q      (en_q),
   .acc_q     (acc_q),
   .rd_valid  (rd_valid),
   .rd_lo     (rd_lo),
   .undef_exc (undef_exc)
);

// File: tb/mac40_cop_test.sv
`timescale 1ns/1ps
module mac40_cop_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = '0;
   logic [31:0] cmd_a = '0, cmd_b = '0;
   logic [1:0]  cmd_sel = '0;
   logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_enable = 1'b0;
   logic        rd_valid, undef_exc;
   logic [31:0] rd_lo, rd_hi;

   int errors = 0;
   int checks = 0;
   logic [39:0] m_acc = '0;
   logic        m_en  = 1'b0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   mac40_cop uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_sel(cmd_sel),
      .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_enable(cfg_enable),
      .rd_valid(rd_valid), .rd_lo(rd_lo), .rd_hi(rd_hi), .undef_exc(undef_exc)
   );

   function automatic longint sx16(input logic [15:0] v);
      return longint'($signed(v));
   endfunction

   function automatic logic [39:0] ref_next(input logic [39:0] acc, input logic [2:0] op,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] sel);
      longint s, p;
      s = longint'($signed(acc));
      case (op)
         3'd1: p = longint'($signed(a)) * longint'($signed(b));
         3'd2: p = sx16(a[31:16]) * sx16(b[31:16]) + sx16(a[15:0]) * sx16(b[15:0]);
         3'd3: p = sx16(sel[1] ? a[31:16] : a[15:0]) * sx16(sel[0] ? b[31:16] : b[15:0]);
         default: p = 0;
      endcase
      if (op == 3'd4) return {b[7:0], a};
      s = s + p;
      return s[39:0];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic priv, input logic val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_priv = priv; cfg_enable = val;
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (priv) m_en = val;
   endtask

   task automatic cmd(input string req, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [1:0] sel);
      logic legal;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b; cmd_sel = sel;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      legal = m_en && op >= 3'd1 && op <= 3'd5;
      check({req, " undef"}, 64'(undef_exc), 64'(!legal));
      check({req, " rd_valid"}, 64'(rd_valid), 64'(legal && op == 3'd5));
      if (legal && op == 3'd5) begin
         check({req, " rd_lo"}, 64'(rd_lo), 64'(m_acc[31:0]));
         check({req, " rd_hi"}, 64'(rd_hi), 64'({{24{m_acc[39]}}, m_acc[39:32]}));
      end
      if (legal) m_acc = ref_next(m_acc, op, a, b, sel);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      check("R1 undef after reset", 64'(undef_exc), 64'd0);
      check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
      // Enable is zero after reset: command must be refused
      cmd("R1 R7 disabled at reset", 3'd1, 32'd5, 32'd7, 2'd0);
      cfg(1'b1, 1'b1);
      cmd("R1 acc zero after reset", 3'd5, 0, 0, 2'd0);

      // R2 wrap modulo 2^40
      cmd("R5 load max", 3'd4, 32'hFFFF_FFFF, 32'h0000_007F, 2'd0);
      cmd("R2 wrap", 3'd1, 32'd1, 32'd1, 2'd0);
      cmd("R2 R6 read wrapped", 3'd5, 0, 0, 2'd0);
      cmd("R2 neg mul", 3'd1, 32'h8000_0000, 32'h8000_0000, 2'd0);
      cmd("R2 read", 3'd5, 0, 0, 2'd0);
      // R3 pair with negatives
      cmd("R5 clear", 3'd4, 0, 0, 2'd0);
      cmd("R3 pair", 3'd2, 32'h8000_FFFF, 32'h8000_0003, 2'd0);
      cmd("R3 read", 3'd5, 0, 0, 2'd0);
      // R4 every select combination
      for (int s = 0; s < 4; s++) begin
         cmd("R4 sel", 3'd3, 32'hFFFE_0003, 32'h0005_FFF9, 2'(s));
         cmd("R4 read", 3'd5, 0, 0, 2'd0);
      end
      // R8 unprivileged write ignored, then R7 refusal keeps acc
      cfg(1'b0, 1'b0);
      cmd("R8 still enabled", 3'd5, 0, 0, 2'd0);
      cfg(1'b1, 1'b0);
      cmd("R7 refused load", 3'd4, 32'h1234_5678, 32'h9A, 2'd0);
      cmd("R7 refused read", 3'd5, 0, 0, 2'd0);
      cfg(1'b0, 1'b1);
      cmd("R8 still disabled", 3'd1, 3, 3, 2'd0);
      cfg(1'b1, 1'b1);
      cmd("R7 acc kept", 3'd5, 0, 0, 2'd0);
      // R9 unassigned opcodes while enabled
      cmd("R9 op0", 3'd0, 32'd9, 32'd9, 2'd0);
      cmd("R9 op6", 3'd6, 32'd9, 32'd9, 2'd0);
      cmd("R9 op7", 3'd7, 32'd9, 32'd9, 2'd0);
      cmd("R9 acc kept", 3'd5, 0, 0, 2'd0);

      // Constrained random mix
      for (int i = 0; i < 1500; i++) begin
         int unsigned pick;
         pick = $urandom_range(0, 99);
         if (pick < 4)
            cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
         else if (pick < 30)
            cmd("R6 rand read", 3'd5, $urandom, $urandom, 2'd0);
         else if (pick < 34)
            cmd("R9 rand op", 3'($urandom_range(0, 7)), $urandom, $urandom, 2'($urandom));
         else
            cmd("R2 R3 R4 R5 rand", 3'($urandom_range(1, 4)), $urandom, $urandom, 2'($urandom));
      end
      cfg(1'b1, 1'b1);
      cmd("R6 final read", 3'd5, 0, 0, 2'd0);
      finish_run();
   end

endmodule